// File: doc/BRIEF.md
# Status and PC Register Write Legalizer

This block keeps a small group of machine-level and supervisor-level control registers for a 64-bit core: the ISA description word, the machine status word, and two exception PC registers (machine and supervisor). Every software write arrives on one write port (strobe, address, data). It is made legal before it is stored, so the registers can never hold a value the rest of the core must not see.

The compressed-instruction enable bit is the only writable bit of the ISA word. A write that would turn it off is refused while the next PC is only 2-byte aligned. Exception PC values are trimmed on write and masked on read according to that bit, and the same alignment mask is driven out for use by other logic. The supervisor status address gives a restricted window onto the machine status word. Reads through it show only the supervisor-visible fields, and writes through it reach only four of them.

A combinational read port returns the legalized view of any mapped address. Address decode beyond these five registers, privilege checks and trap sequencing belong to neighbouring logic.

Top module: `csr_write_legalizer`

## Requirements
- R1: A write to the ISA word (address 0x301) can change only bit 2, the compressed enable. Every other bit keeps its value, whatever the write data holds.
- R2: An ISA write with data bit 2 equal to 0 is dropped, leaving the word unchanged, when `next_pc_b1_i` is 1. With `next_pc_b1_i` equal to 0 the clear takes effect. Setting bit 2 is always accepted.
- R3: A write to either exception PC (machine 0x341, supervisor 0x141) stores the data with bit 0 cleared. Bit 1 is also cleared when ISA bit 2 is 0 at the time of the write.
- R4: `pc_align_mask_o` is all ones while ISA bit 2 is 1, and all ones except bit 1 while it is 0. A read of either exception PC returns the stored value ANDed with this mask.
- R5: A read of the supervisor status address (0x100) returns the machine status word with every bit cleared except bits 63, 33:32, 19, 18, 16:15, 14:13, 8, 5, 4, 1 and 0.
- R6: A write to the supervisor status address updates only machine status bits 63 (dirty summary), 19, 18 and 16:15. Bits 33:32 (user width) and all other bits keep their value.
- R7: A write to the machine status address (0x300) stores all bits except 35:34 and 33:32, the supervisor and user width fields, which keep their value.
- R8: After reset the ISA word is 0x8000_0000_0004_0105: width code 2 in bits 63:62, with bits 0, 2, 8 and 18 set. The machine status word is 0x0000_000A_0000_0000: both width fields equal 2, and the dirty summary and all other bits are 0. Both exception PCs are 0.
- R9: A write becomes visible on the read port after the first rising clock edge at which the strobe is sampled high, and not before. Without the strobe, or at an unmapped address, no register changes. A read of an unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 12 | Write address |
| wr_data_i | input | 64 | Write data, before legalization |
| next_pc_b1_i | input | 1 | Bit 1 of the core's next PC |
| rd_addr_i | input | 12 | Read address |
| rd_data_o | output | 64 | Legalized read data, combinational from the read address |
| pc_align_mask_o | output | 64 | Mask to AND with any exception PC before it is used |

## Verification
The bench builds the block with its default parameters: 12-bit addresses, the standard addresses for the five registers, and a reset extension set that includes the compressed bit. Because the compressed bit starts at 1, the bench can refuse a clear under a misaligned next PC first, then perform a clear, then set the bit again. This lets it observe both exception PC masks on the same stored values. Directed writes of all ones and all zeros through both status addresses show which fields each address reaches. A long pseudo-random stream then mixes all five addresses, an unmapped one and both next-PC alignments against a behavioural model.

// File: rtl/csr_legal_pkg.sv
package csr_legal_pkg;

    localparam int XLEN     = 64;
    localparam int NUM_EPC  = 2;

    // field positions inside the ISA and status words
    localparam int C_BIT    = 2;
    localparam int MXL_LO   = XLEN - 2;
    localparam int SD_BIT   = XLEN - 1;
    localparam int SXL_LO   = 34;
    localparam int UXL_LO   = 32;
    localparam int MXR_BIT  = 19;
    localparam int SUM_BIT  = 18;
    localparam int XS_LO    = 15;
    localparam int FS_LO    = 13;
    localparam int SPP_BIT  = 8;
    localparam int SPIE_BIT = 5;
    localparam int UPIE_BIT = 4;
    localparam int SIE_BIT  = 1;
    localparam int UIE_BIT  = 0;

    localparam logic [1:0] WIDTH_CODE_64 = 2'd2;

    typedef logic [XLEN-1:0] xword_t;

    function automatic xword_t field_mask(int lo, int w);
        return ((xword_t'(1) << w) - xword_t'(1)) << lo;
    endfunction

    // width fields that no write may alter
    localparam xword_t WIDTH_FIELDS = field_mask(UXL_LO, 4);
    // fields a supervisor-status write may reach
    localparam xword_t SWR_MASK  = field_mask(SD_BIT, 1) | field_mask(MXR_BIT, 1)
                                 | field_mask(SUM_BIT, 1) | field_mask(XS_LO, 2);
    // fields visible through the supervisor-status window
    localparam xword_t SVIEW_MASK = SWR_MASK | field_mask(UXL_LO, 2) | field_mask(FS_LO, 2)
                                  | field_mask(SPP_BIT, 1) | field_mask(SPIE_BIT, 1)
                                  | field_mask(UPIE_BIT, 1) | field_mask(SIE_BIT, 1)
                                  | field_mask(UIE_BIT, 1);

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ISA,
        SEL_MSTAT,
        SEL_SSTAT,
        SEL_MEPC,
        SEL_SEPC
    } csr_sel_e;

    typedef struct packed {
        xword_t                        isa;
        xword_t                        mstat;
        logic [NUM_EPC-1:0][XLEN-1:0]  epc;   // index 0 machine, 1 supervisor
    } csr_state_t;

endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
    import csr_legal_pkg::*;
#(
    parameter int                ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] A_ISA   = 12'h301,
    parameter logic [ADDR_W-1:0] A_MSTAT = 12'h300,
    parameter logic [ADDR_W-1:0] A_SSTAT = 12'h100,
    parameter logic [ADDR_W-1:0] A_MEPC  = 12'h341,
    parameter logic [ADDR_W-1:0] A_SEPC  = 12'h141
) (
    input  logic [ADDR_W-1:0] addr_i,
    output csr_sel_e          sel_o
);

    always_comb begin
        if      (addr_i == A_ISA)   sel_o = SEL_ISA;
        else if (addr_i == A_MSTAT) sel_o = SEL_MSTAT;
        else if (addr_i == A_SSTAT) sel_o = SEL_SSTAT;
        else if (addr_i == A_MEPC)  sel_o = SEL_MEPC;
        else if (addr_i == A_SEPC)  sel_o = SEL_SEPC;
        else                        sel_o = SEL_NONE;
    end

endmodule

// File: rtl/csr_isa_legalize.sv
module csr_isa_legalize
    import csr_legal_pkg::*;
(
    input  xword_t cur_i,
    input  logic   wr_c_i,
    input  logic   npc_b1_i,
    output xword_t next_o,
    output logic   c_on_o,
    output xword_t align_mask_o
);

    logic refuse;

    always_comb begin
        // turning compressed off with a half-aligned next PC would strand it
        refuse = !wr_c_i && npc_b1_i;
        next_o = cur_i;
        if (!refuse) begin
            next_o[C_BIT] = wr_c_i;
        end
        c_on_o       = cur_i[C_BIT];
        align_mask_o = c_on_o ? '1 : ~(xword_t'(1) << 1);
    end

endmodule

// File: rtl/csr_status_legalize.sv
module csr_status_legalize
    import csr_legal_pkg::*;
(
    input  xword_t cur_i,
    input  xword_t wdata_i,
    input  logic   sview_i,
    output xword_t next_o,
    output xword_t view_o
);

    xword_t keep;

    always_comb begin
        keep   = sview_i ? ~SWR_MASK : WIDTH_FIELDS;
        next_o = (wdata_i & ~keep) | (cur_i & keep);
        view_o = cur_i & SVIEW_MASK;
    end

endmodule

// File: rtl/csr_epc_legalize.sv
module csr_epc_legalize
    import csr_legal_pkg::*;
(
    input  logic   c_on_i,
    input  xword_t wdata_i,
    input  xword_t stored_i,
    input  xword_t align_mask_i,
    output xword_t wr_val_o,
    output xword_t rd_val_o
);

    xword_t low_clear;

    always_comb begin
        low_clear = c_on_i ? xword_t'(1) : xword_t'(3);
        wr_val_o  = wdata_i & ~low_clear;
        rd_val_o  = stored_i & align_mask_i;
    end

endmodule

// File: rtl/csr_write_legalizer.sv
module csr_write_legalizer
    import csr_legal_pkg::*;
#(
    parameter int                ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] A_ISA   = 12'h301,
    parameter logic [ADDR_W-1:0] A_MSTAT = 12'h300,
    parameter logic [ADDR_W-1:0] A_SSTAT = 12'h100,
    parameter logic [ADDR_W-1:0] A_MEPC  = 12'h341,
    parameter logic [ADDR_W-1:0] A_SEPC  = 12'h141,
    parameter logic [25:0]       RST_EXT = 26'h0040105
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [XLEN-1:0]   wr_data_i,
    input  logic              next_pc_b1_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [XLEN-1:0]   rd_data_o,
    output logic [XLEN-1:0]   pc_align_mask_o
);

    localparam int     NUM_PORTS = 2;   // 0 write, 1 read
    localparam xword_t ISA_RST   = (xword_t'(WIDTH_CODE_64) << MXL_LO) | xword_t'(RST_EXT);
    localparam xword_t MSTAT_RST = (xword_t'(WIDTH_CODE_64) << SXL_LO)
                                 | (xword_t'(WIDTH_CODE_64) << UXL_LO);

    csr_state_t state_d, state_q;

    logic [NUM_PORTS-1:0][ADDR_W-1:0] port_addr;
    csr_sel_e                         port_sel [NUM_PORTS];
    csr_sel_e                         wr_sel, rd_sel;

    assign port_addr = {rd_addr_i, wr_addr_i};

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dec
        csr_addr_decode #(
            .ADDR_W (ADDR_W),
            .A_ISA  (A_ISA),
            .A_MSTAT(A_MSTAT),
            .A_SSTAT(A_SSTAT),
            .A_MEPC (A_MEPC),
            .A_SEPC (A_SEPC)
        ) u_dec (
            .addr_i(port_addr[p]),
            .sel_o (port_sel[p])
        );
    end

    assign wr_sel = port_sel[0];
    assign rd_sel = port_sel[1];

    xword_t isa_next, align_mask;
    logic   c_on;

    csr_isa_legalize u_isa (
        .cur_i       (state_q.isa),
        .wr_c_i      (wr_data_i[C_BIT]),
        .npc_b1_i    (next_pc_b1_i),
        .next_o      (isa_next),
        .c_on_o      (c_on),
        .align_mask_o(align_mask)
    );

    xword_t stat_next, stat_view;

    csr_status_legalize u_stat (
        .cur_i  (state_q.mstat),
        .wdata_i(wr_data_i),
        .sview_i(wr_sel == SEL_SSTAT),
        .next_o (stat_next),
        .view_o (stat_view)
    );

    xword_t epc_wr [NUM_EPC];
    xword_t epc_rd [NUM_EPC];

    for (genvar g = 0; g < NUM_EPC; g++) begin : g_epc
        csr_epc_legalize u_epc (
            .c_on_i      (c_on),
            .wdata_i     (wr_data_i),
            .stored_i    (state_q.epc[g]),
            .align_mask_i(align_mask),
            .wr_val_o    (epc_wr[g]),
            .rd_val_o    (epc_rd[g])
        );
    end

    always_comb begin
        state_d = state_q;
        if (wr_en_i) begin
            case (wr_sel)
                SEL_ISA:              state_d.isa    = isa_next;
                SEL_MSTAT, SEL_SSTAT: state_d.mstat  = stat_next;
                SEL_MEPC:             state_d.epc[0] = epc_wr[0];
                SEL_SEPC:             state_d.epc[1] = epc_wr[1];
                default:              ;
            endcase
        end

        case (rd_sel)
            SEL_ISA:   rd_data_o = state_q.isa;
            SEL_MSTAT: rd_data_o = state_q.mstat;
            SEL_SSTAT: rd_data_o = stat_view;
            SEL_MEPC:  rd_data_o = epc_rd[0];
            SEL_SEPC:  rd_data_o = epc_rd[1];
            default:   rd_data_o = '0;
        endcase

        pc_align_mask_o = align_mask;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q.isa   <= ISA_RST;
            state_q.mstat <= MSTAT_RST;
            state_q.epc   <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/csr_write_legalizer_chk.sv
module csr_write_legalizer_chk
    import csr_legal_pkg::*;
#(
    parameter int                ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] A_ISA   = 12'h301,
    parameter logic [ADDR_W-1:0] A_SSTAT = 12'h100,
    parameter logic [ADDR_W-1:0] A_MEPC  = 12'h341
) (
    input logic                         clk_i,
    input logic                         rst_ni,
    input logic                         wr_en_i,
    input logic [ADDR_W-1:0]            wr_addr_i,
    input logic                         wr_c_i,
    input logic                         npc_b1_i,
    input logic [ADDR_W-1:0]            rd_addr_i,
    input logic [XLEN-1:0]              rd_data_i,
    input logic [XLEN-1:0]              mask_i,
    input logic [XLEN-1:0]              isa_i,
    input logic [XLEN-1:0]              mstat_i,
    input logic [NUM_EPC-1:0][XLEN-1:0] epc_i
);

    // R1: an ISA write leaves every bit but the compressed bit as it was
    a_r1_isa_fixed_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i == A_ISA)
        |=> (isa_i[XLEN-1:C_BIT+1] == $past(isa_i[XLEN-1:C_BIT+1]))
            && (isa_i[C_BIT-1:0] == $past(isa_i[C_BIT-1:0])));

    // R2: a clear under a half-aligned next PC is refused
    a_r2_clear_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i == A_ISA && !wr_c_i && npc_b1_i) |=> $stable(isa_i));

    // R3: stored exception PCs never have bit 0 set
    a_r3_epc_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !epc_i[0][0] && !epc_i[1][0]);

    // R3: with compressed off, a machine EPC write clears bit 1
    a_r3_epc_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i == A_MEPC && !isa_i[C_BIT]) |=> !epc_i[0][1]);

    // R4: the mask never clears bit 0 and clears at most one bit
    a_r4_mask_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mask_i[0] && ($countones(~mask_i) <= 1));

    // R5: the supervisor window shows nothing outside its fields
    a_r5_view_zeros: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_addr_i == A_SSTAT) |-> ((rd_data_i & ~SVIEW_MASK) == '0));

    // R6: a supervisor-status write keeps the user width field
    a_r6_uxl_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i == A_SSTAT)
        |=> (mstat_i[UXL_LO+1:UXL_LO] == $past(mstat_i[UXL_LO+1:UXL_LO])));

    // R9: with no strobe nothing moves
    a_r9_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i |=> $stable({isa_i, mstat_i, epc_i}));

endmodule

bind csr_write_legalizer csr_write_legalizer_chk #(
    .ADDR_W (ADDR_W),
    .A_ISA  (A_ISA),
    .A_SSTAT(A_SSTAT),
    .A_MEPC (A_MEPC)
) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_c_i   (wr_data_i[2]),
    .npc_b1_i (next_pc_b1_i),
    .rd_addr_i(rd_addr_i),
    .rd_data_i(rd_data_o),
    .mask_i   (pc_align_mask_o),
    .isa_i    (state_q.isa),
    .mstat_i  (state_q.mstat),
    .epc_i    (state_q.epc)
);

// File: tb/csr_write_legalizer_tb.sv
module csr_write_legalizer_tb;

    localparam logic [11:0] AD_ISA = 12'h301, AD_MST = 12'h300, AD_SST = 12'h100;
    localparam logic [11:0] AD_MEP = 12'h341, AD_SEP = 12'h141, AD_BAD = 12'h7C0;
    localparam logic [63:0] ONES   = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] VIEW   = 64'h8000_0003_000D_E133;
    localparam logic [63:0] SWR    = 64'h8000_0000_000D_8000;
    localparam logic [63:0] WIDTHS = 64'h0000_000F_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic        npc_b1 = 1'b0;
    logic [11:0] rd_addr = '0;
    logic [63:0] rd_data, mask;

    always #10 clk = ~clk;   // 50 MHz

    csr_write_legalizer u_dut (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .wr_en_i        (wr_en),
        .wr_addr_i      (wr_addr),
        .wr_data_i      (wr_data),
        .next_pc_b1_i   (npc_b1),
        .rd_addr_i      (rd_addr),
        .rd_data_o      (rd_data),
        .pc_align_mask_o(mask)
    );

    int    n_checks = 0;
    int    n_errs   = 0;
    bit    live     = 1'b0;
    string cur_req  = "R8";

    // behavioural reference state
    logic [63:0] m_isa, m_mst, m_mep, m_sep;

    function automatic logic [63:0] m_mask();
        return m_isa[2] ? ONES : ~64'h2;
    endfunction

    function automatic logic [63:0] m_read(logic [11:0] a);
        case (a)
            AD_ISA:  return m_isa;
            AD_MST:  return m_mst;
            AD_SST:  return m_mst & VIEW;
            AD_MEP:  return m_mep & m_mask();
            AD_SEP:  return m_sep & m_mask();
            default: return 64'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_isa = 64'h8000_0000_0004_0105;
            m_mst = 64'h0000_000A_0000_0000;
            m_mep = 64'h0;
            m_sep = 64'h0;
        end else if (wr_en) begin
            case (wr_addr)
                AD_ISA: if (wr_data[2] || !npc_b1) m_isa[2] = wr_data[2];
                AD_MST: m_mst = (wr_data & ~WIDTHS) | (m_mst & WIDTHS);
                AD_SST: m_mst = (wr_data & SWR) | (m_mst & ~SWR);
                AD_MEP: m_mep = wr_data & (m_isa[2] ? ~64'h1 : ~64'h3);
                AD_SEP: m_sep = wr_data & (m_isa[2] ? ~64'h1 : ~64'h3);
                default: ;
            endcase
        end
    end

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp, string what);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // one clock: compare last cycle's outputs with the model, then drive
    task automatic step(bit we, logic [11:0] wa, logic [63:0] wd, logic [11:0] ra);
        @(negedge clk);
        if (live) begin
            check(rd_data == m_read(rd_addr), cur_req, rd_data, m_read(rd_addr), "model read");
            check(mask == m_mask(), "R4", mask, m_mask(), "model mask");
        end
        wr_en   = we;
        wr_addr = wa;
        wr_data = wd;
        rd_addr = ra;
        live    = 1'b1;
    endtask

    task automatic rd_lit(logic [11:0] ra, logic [63:0] exp, string req);
        step(1'b0, AD_BAD, 64'h0, ra);
        #1;
        check(rd_data == exp, req, rd_data, exp, "literal read");
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_errs++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin : stim
        logic [63:0] r;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R8 reset values
        cur_req = "R8";
        rd_lit(AD_ISA, 64'h8000_0000_0004_0105, "R8");
        rd_lit(AD_MST, 64'h0000_000A_0000_0000, "R8");
        rd_lit(AD_MEP, 64'h0, "R8");
        rd_lit(AD_SST, 64'h0000_0002_0000_0000, "R5");

        // R3 with compressed on: only bit 0 trimmed
        cur_req = "R3";
        step(1'b1, AD_MEP, ONES, AD_MEP);
        rd_lit(AD_MEP, 64'hFFFF_FFFF_FFFF_FFFE, "R3");
        check(mask == ONES, "R4", mask, ONES, "mask with compressed on");

        // R2 clear refused while next PC is half aligned; R1 other bits kept
        cur_req = "R2";
        npc_b1 = 1'b1;
        step(1'b1, AD_ISA, 64'h0, AD_ISA);
        rd_lit(AD_ISA, 64'h8000_0000_0004_0105, "R2");
        npc_b1 = 1'b0;
        step(1'b1, AD_ISA, 64'hFFFF_FFFF_FFFF_FFFB, AD_ISA);
        rd_lit(AD_ISA, 64'h8000_0000_0004_0101, "R1");

        // R4 mask and EPC read with compressed off
        cur_req = "R4";
        rd_lit(AD_MEP, 64'hFFFF_FFFF_FFFF_FFFC, "R4");
        check(mask == 64'hFFFF_FFFF_FFFF_FFFD, "R4", mask, 64'hFFFF_FFFF_FFFF_FFFD, "mask off");

        // R3 with compressed off: bits 1 and 0 trimmed
        cur_req = "R3";
        step(1'b1, AD_SEP, 64'h1234_5678_9ABC_DEF7, AD_SEP);
        rd_lit(AD_SEP, 64'h1234_5678_9ABC_DEF4, "R3");

        // R2 setting is accepted even with a half-aligned next PC
        cur_req = "R2";
        npc_b1 = 1'b1;
        step(1'b1, AD_ISA, 64'h4, AD_ISA);
        rd_lit(AD_ISA, 64'h8000_0000_0004_0105, "R2");
        npc_b1 = 1'b0;

        // R7 machine status keeps its width fields
        cur_req = "R7";
        step(1'b1, AD_MST, ONES, AD_MST);
        rd_lit(AD_MST, 64'hFFFF_FFFA_FFFF_FFFF, "R7");
        rd_lit(AD_SST, 64'h8000_0002_000D_E133, "R5");

        // R6 supervisor write reaches only four fields
        cur_req = "R6";
        step(1'b1, AD_SST, 64'h0, AD_MST);
        rd_lit(AD_MST, 64'h7FFF_FFFA_FFF2_7FFF, "R6");
        step(1'b1, AD_SST, 64'h8000_0000_0000_8000, AD_MST);
        rd_lit(AD_MST, 64'hFFFF_FFFA_FFF2_FFFF, "R6");

        // R9 unmapped address, and write timing
        cur_req = "R9";
        step(1'b1, AD_BAD, 64'h0, AD_MST);
        rd_lit(AD_MST, 64'hFFFF_FFFA_FFF2_FFFF, "R9");
        rd_lit(AD_BAD, 64'h0, "R9");
        step(1'b1, AD_MEP, 64'h100, AD_MEP);
        #1;
        check(rd_data == 64'hFFFF_FFFF_FFFF_FFFE, "R9", rd_data, 64'hFFFF_FFFF_FFFF_FFFE, "before edge");
        rd_lit(AD_MEP, 64'h100, "R9");

        // mixed pseudo-random traffic against the model
        r = 64'h9E37_79B9_7F4A_7C15;
        for (int i = 0; i < 600; i++) begin
            logic [11:0] wa, ra;
            r = r ^ (r << 13);
            r = r ^ (r >> 7);
            r = r ^ (r << 17);
            case (r[2:0] % 3'd6)
                3'd0: wa = AD_ISA;  3'd1: wa = AD_MST;  3'd2: wa = AD_SST;
                3'd3: wa = AD_MEP;  3'd4: wa = AD_SEP;  default: wa = AD_BAD;
            endcase
            case (r[50:48] % 3'd6)
                3'd0: ra = AD_ISA;  3'd1: ra = AD_MST;  3'd2: ra = AD_SST;
                3'd3: ra = AD_MEP;  3'd4: ra = AD_SEP;  default: ra = AD_BAD;
            endcase
            npc_b1 = r[40];
            step(r[33], wa, r, ra);
        end
        step(1'b0, AD_BAD, 64'h0, AD_ISA);

        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule